// File: doc/BRIEF.md
# Serial Bit-Pair Partial-Product Row Generator

This block takes two unsigned N-bit operands one bit of each per accepted beat and emits one full row of partial-product bits for every beat. Operand X is sent starting from its top bit (bit N-1), and operand Y starting from its bottom bit (bit 0). Each row is a 2N-1 bit vector. Bit c of the vector carries the product bit whose arithmetic weight is 2^c, so a downstream column-wise accumulator can add rows without shifting them.

Two age lines hold the bits already received. The X line shifts toward higher columns and the Y line toward lower columns. An array of AND gates pairs the freshly accepted bit of each operand with every older bit of the other operand, and the fresh pair itself drives the centre column N-1. Row r (counted from 0) therefore fills the centred band of columns N-1-r through N-1+r. After N rows, each of the N*N products x[i]&y[j] has appeared exactly once.

Bits come in on a valid/ready stream and rows leave on a valid/ready stream. A beat is taken when `in_valid` and `in_ready` are both high at a clock edge. A row is handed over when `row_valid` and `row_ready` are both high. While a row waits, it is held unchanged and no new beat is taken. `start` is a plain control pulse that opens a new operation.

Top module: `pp_row_serial`

## Requirements
- R1: After reset, `row_valid` is 0, `row_out` is all zero, and `in_ready` stays 0 until `start` has been seen. Beats offered before `start` produce no row.
- R2: In the cycle `start` is high, `in_ready` is 0. In the next cycle, `in_ready` is 1 and `row_valid` is 0.
- R3: In the row for beat r, every column below N-1-r and every column above N-1+r is 0.
- R4: Column N-1 of the row for beat r equals x[N-1-r] AND y[r], the two bits taken in that beat.
- R5: In the row for beat r, column c within the band equals x[i] AND y[j] with i+j=c. Here either i=N-1-r and j<=r, or j=r and i>=N-1-r.
- R6: An operation yields exactly N rows. `row_last` is 1 on the N-th row only. After the N-th beat is taken, `in_ready` stays 0 until the next `start`.
- R7: While `row_valid`=1 and `row_ready`=0, `row_out` and `row_last` hold their values, `row_valid` stays 1, and `in_ready` is 0.
- R8: The sum over all N rows of sum_c row_out[c]*2^c equals X*Y.
- R9: A `start` in the middle of an operation discards the held bits and any pending row. The rows of the next operation depend only on its own bits.
- R10: A cycle with `in_valid`=0 takes no beat, so the next row is not produced until a beat is accepted. A row already delivered is not repeated.
- R11: A row is visible on the cycle after its beat is accepted, provided the output was empty or is being drained in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new operation; clears the held bits |
| in_valid | input | 1 | A bit pair is offered |
| in_ready | output | 1 | Block can take the offered pair |
| x_in | input | 1 | Bit of X, top bit first |
| y_in | input | 1 | Bit of Y, bottom bit first |
| row_out | output | 2N-1 | Partial-product row, bit c has weight 2^c |
| row_valid | output | 1 | `row_out` holds a row |
| row_ready | input | 1 | Consumer takes the row |
| row_last | output | 1 | This row is the N-th of the operation |

## Verification
Each row is compared against the full column formula for several operand pairs. All ones fills every band completely, which exposes any missing AND term. All zeros in X shows whether any term leaks through when the fresh X bit is 0. Sparse corner values (top bit of X with bottom bit of Y) isolate single columns and show whether the weights are placed in the correct columns. A mid-row stall, a hole in the input stream and a restart after a half-fed operation of all ones separately test whether rows are held, whether rows are duplicated, and whether stale bits are cleared. The sum of the weighted rows against X*Y ties all of these together.

// File: rtl/pp_row_serial_pkg.sv
package pp_row_serial_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

endpackage

// File: rtl/pp_age_line.sv
// Holds the bits taken on previous beats, indexed by age:
// taps[k] is the bit accepted k+1 beats ago.
module pp_age_line #(
  parameter int DEPTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        taps <= '0;
        else if (clear)    taps <= '0;
        else if (shift_en) taps <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        taps <= '0;
        else if (clear)    taps <= '0;
        else if (shift_en) taps <= {taps[DEPTH-2:0], din};
      end
    end
  endgenerate

endmodule

// File: rtl/pp_row_and_array.sv
// Pairs the fresh bits with every older bit of the other operand.
// An X bit of age k sits k+1 columns above the centre.
// A Y bit of age k sits k+1 columns below the centre.
module pp_row_and_array #(
  parameter int N = 8,
  localparam int W = 2*N-1,
  localparam int A = N-1
) (
  input  logic         x_new,
  input  logic         y_new,
  input  logic [A-1:0] x_age,
  input  logic [A-1:0] y_age,
  output logic [W-1:0] row
);

  assign row[N-1] = x_new & y_new;

  generate
    for (genvar k = 0; k < A; k++) begin : g_cols
      assign row[N+k]   = y_new & x_age[k];
      assign row[N-2-k] = x_new & y_age[k];
    end
  endgenerate

endmodule

// File: rtl/pp_seq_ctrl.sv
// Beat counting, stream handshakes and the last-row flag.
module pp_seq_ctrl
  import pp_row_serial_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = $clog2(N+1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic row_ready,
  output logic in_ready,
  output logic take,
  output logic row_valid,
  output logic row_last
);

  phase_t        phase_q;
  logic [CW-1:0] beat_q;
  logic          final_beat;
  logic          out_free;

  assign out_free   = !row_valid || row_ready;
  assign in_ready   = (phase_q == PH_RUN) && !start && out_free;
  assign take       = in_valid && in_ready;
  assign final_beat = (beat_q == CW'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      beat_q  <= '0;
    end else if (start) begin
      phase_q <= PH_RUN;
      beat_q  <= '0;
    end else if (take) begin
      beat_q <= beat_q + CW'(1);
      if (final_beat) phase_q <= PH_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_last  <= 1'b0;
    end else if (start) begin
      row_valid <= 1'b0;
      row_last  <= 1'b0;
    end else if (take) begin
      row_valid <= 1'b1;
      row_last  <= final_beat;
    end else if (row_ready) begin
      row_valid <= 1'b0;
      row_last  <= 1'b0;
    end
  end

endmodule

// File: rtl/pp_row_serial.sv
module pp_row_serial #(
  parameter int N = 8,
  localparam int W = 2*N-1,
  localparam int A = N-1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         x_in,
  input  logic         y_in,
  output logic [W-1:0] row_out,
  output logic         row_valid,
  input  logic         row_ready,
  output logic         row_last
);

  logic         take;
  logic [A-1:0] x_age;
  logic [A-1:0] y_age;
  logic [W-1:0] row_next;

  pp_seq_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .row_ready (row_ready),
    .in_ready  (in_ready),
    .take      (take),
    .row_valid (row_valid),
    .row_last  (row_last)
  );

  pp_age_line #(.DEPTH(A)) u_x_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .shift_en (take),
    .din      (x_in),
    .taps     (x_age)
  );

  pp_age_line #(.DEPTH(A)) u_y_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .shift_en (take),
    .din      (y_in),
    .taps     (y_age)
  );

  pp_row_and_array #(.N(N)) u_and (
    .x_new (x_in),
    .y_new (y_in),
    .x_age (x_age),
    .y_age (y_age),
    .row   (row_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_out <= '0;
    else if (take) row_out <= row_next;
  end

endmodule

// File: rtl/pp_row_serial_chk.sv
module pp_row_serial_chk #(
  parameter int N = 8,
  localparam int W = 2*N-1,
  localparam int CW = $clog2(N+1)+1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         in_valid,
  input logic         in_ready,
  input logic         x_in,
  input logic         y_in,
  input logic [W-1:0] row_out,
  input logic         row_valid,
  input logic         row_ready,
  input logic         row_last
);

  logic [CW-1:0] seen_q;
  logic          centre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= '0;
      centre_q <= 1'b0;
    end else if (start) begin
      seen_q   <= '0;
    end else if (in_valid && in_ready) begin
      seen_q   <= seen_q + CW'(1);
      centre_q <= x_in & y_in;
    end
  end

  function automatic logic [W-1:0] band_of(input int r);
    logic [W-1:0] m;
    for (int c = 0; c < W; c++)
      m[c] = (c >= N-1-r) && (c <= N-1+r);
    return m;
  endfunction

  a_r2_start_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);

  a_r3_band_only: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> ((row_out & ~band_of(int'(seen_q) - 1)) == '0));

  a_r4_centre_pair: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> (row_out[N-1] == centre_q));

  a_r6_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (seen_q < CW'(N)));

  a_r6_last_on_nth: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_last) |-> (seen_q == CW'(N)));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !row_ready && !start) |=>
      (row_valid && $stable(row_out) && $stable(row_last)));

endmodule

bind pp_row_serial pp_row_serial_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .x_in      (x_in),
  .y_in      (y_in),
  .row_out   (row_out),
  .row_valid (row_valid),
  .row_ready (row_ready),
  .row_last  (row_last)
);

// File: tb/pp_row_serial_bench.sv
module pp_row_serial_bench;

  localparam int N = 8;
  localparam int W = 2*N-1;

  logic         clk = 1'b0;
  logic         rst_n, start, in_valid, x_in, y_in, row_ready;
  logic         in_ready, row_valid, row_last;
  logic [W-1:0] row_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  pp_row_serial #(.N(N)) u_pp_row_serial (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .x_in(x_in), .y_in(y_in), .row_out(row_out),
    .row_valid(row_valid), .row_ready(row_ready), .row_last(row_last)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_row(input logic [N-1:0] x, input logic [N-1:0] y, input int r);
    logic [W-1:0] v = '0;
    for (int c = 0; c < W; c++)
      for (int i = 0; i < N; i++) begin
        int j = c - i;
        if (j >= 0 && j < N && i >= N-1-r && j <= r && (i == N-1-r || j == r))
          v[c] = v[c] | (x[i] & y[j]);
      end
    return v;
  endfunction

  function automatic logic [W-1:0] band(input int r);
    logic [W-1:0] m;
    for (int c = 0; c < W; c++) m[c] = (c >= N-1-r) && (c <= N-1+r);
    return m;
  endfunction

  task automatic do_start();
    @(negedge clk);
    in_valid = 1'b0;
    start = 1'b1;
    #1 check("R2 in_ready low during start", 64'(in_ready), 64'd0);
    @(negedge clk);
    start = 1'b0;
    #1 check("R2 in_ready after start", 64'(in_ready), 64'd1);
    check("R2 row_valid after start", 64'(row_valid), 64'd0);
  endtask

  task automatic run_op(input string tag, input logic [N-1:0] x, input logic [N-1:0] y,
                        input int stall_at, input int gap_at);
    logic [63:0]  acc = 0;
    logic [W-1:0] e;
    do_start();
    row_ready = 1'b1;
    in_valid = 1'b1; x_in = x[N-1]; y_in = y[0];
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      e = exp_row(x, y, r);
      // R11: row visible the cycle after its beat
      check({tag, " R11 row_valid"}, 64'(row_valid), 64'd1);
      check({tag, " R5 row bits"}, 64'(row_out), 64'(e));
      check({tag, " R3 outside band"}, 64'(row_out & ~band(r)), 64'd0);
      check({tag, " R4 centre"}, 64'(row_out[N-1]), 64'(x[N-1-r] & y[r]));
      check({tag, " R6 last flag"}, 64'(row_last), 64'(r == N-1));
      for (int c = 0; c < W; c++) if (row_out[c]) acc += (64'd1 << c);
      if (r < N-1) begin x_in = x[N-2-r]; y_in = y[r+1]; in_valid = 1'b1; end
      else in_valid = 1'b0;
      if (r == stall_at) begin
        row_ready = 1'b0;
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          #1;
          check({tag, " R7 held row"}, 64'(row_out), 64'(e));
          check({tag, " R7 valid kept"}, 64'(row_valid), 64'd1);
          check({tag, " R7 no intake"}, 64'(in_ready), 64'd0);
        end
        row_ready = 1'b1;
      end
      if (r == gap_at && r < N-1) begin
        in_valid = 1'b0;
        @(negedge clk);
        check({tag, " R10 no row in gap"}, 64'(row_valid), 64'd0);
        in_valid = 1'b1;
      end
    end
    check({tag, " R8 product"}, acc, 64'(x) * 64'(y));
    in_valid = 1'b1;
    @(negedge clk);
    #1;
    check({tag, " R6 done row_valid"}, 64'(row_valid), 64'd0);
    check({tag, " R6 done in_ready"}, 64'(in_ready), 64'd0);
    @(negedge clk);
    check({tag, " R6 no extra row"}, 64'(row_valid), 64'd0);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 row_valid at reset", 64'(row_valid), 64'd0);
    check("R1 row_out at reset", 64'(row_out), 64'd0);
    check("R1 in_ready at reset", 64'(in_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1; x_in = 1'b1; y_in = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 no intake before start", 64'(in_ready), 64'd0);
    check("R1 no row before start", 64'(row_valid), 64'd0);
    in_valid = 1'b0;
  endtask

  task automatic t_restart();
    do_start();
    row_ready = 1'b1;
    in_valid = 1'b1; x_in = 1'b1; y_in = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R9 partial op running", 64'(row_valid), 64'd1);
    run_op("R9 restart", 8'h81, 8'h01, -1, -1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; x_in = 1'b0; y_in = 1'b0; row_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    run_op("mixed", 8'hB5, 8'h6D, -1, -1);
    run_op("ones", 8'hFF, 8'hFF, -1, -1);
    run_op("zeroX", 8'h00, 8'h3C, -1, -1);
    run_op("corner", 8'h80, 8'h01, -1, -1);
    run_op("stall", 8'hA7, 8'h5B, 2, -1);
    run_op("gap", 8'h5A, 8'hC3, -1, 4);
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule